// File: doc/BRIEF.md
# Linear CCD Line and Exposure Sequencer

This block sets the line-level rhythm of a three-colour linear CCD. It counts pixel ticks, which another block supplies as one-cycle strobes, and uses the count to frame each sensor line. A 3-bit sensor code chooses the line length from a fixed table. On lines that carry a charge transfer, the block raises the two transfer-gate outputs at the start of the line. An integration setting spaces these transfer lines one to four line times apart, so charge can build up in the photodiodes for longer.

Two exposure-control gates, one for red and one for green, shorten the effective exposure of their colours. Each gate has its own 4-bit code. The code turns the gate off for good, turns it on for a window that is a whole multiple of 500 pixels, or keeps it on at all times except while the transfer gates are active. The block also drives line and frame sync pulses for a frame grabber. The sensor code and the integration code are sampled only when a line begins. The exposure codes take effect at once.

Top module: `ccdLineSequencer`

## Requirements
- R1: Pixel position 0 of a line holds for one tick. Each `pixelTick` then moves the position up by one. A cycle without a tick leaves it unchanged. After position L-1 the next tick starts a new line. L is set by `sensorSel`: 0→2872, 1→6372, 2→8572, 3→10372, 4→2472, 5→14972, 6→172, 7→14972.
- R2: On a transfer line, `tg1` is high for pixel positions 0 to 20 and `tg2` is high for positions 0 to 25. On any other pixel or line, both are low.
- R3: Let n be the value of `intSel[1:0]`. Transfer lines then occur once every n+1 lines, and `intSel[2]` has no effect. The first line after reset is a transfer line. At each line start, the new line is a transfer line if the lines since the last transfer line number at least the newly sampled n+1. This rule also covers an integration code that is lowered partway through a group.
- R4: `lineSync` is high for pixel positions 0 to 9 of every line.
- R5: `frameSync` is high for pixel positions 0 to 9 of transfer lines only.
- R6: For an exposure code k from 1 to 14, the gate is high on every line from pixel 26 up to but not including pixel 26+500·k. The window is cut short at the end of the line.
- R7: An exposure code of 0 holds the gate low.
- R8: An exposure code of 15 holds the gate high, except for pixel positions 0 to 25 of a transfer line, where it is low.
- R9: `expRed` depends only on `redCode` and `expGreen` depends only on `greenCode`. Each code acts on the cycle it is applied.
- R10: `sensorSel` and `intSel` are sampled only on the tick that starts a line. A change partway through a line does not affect the current line's length or transfer status.
- R11: From reset until the first `pixelTick`, all outputs are low. That first tick starts pixel 0 of a transfer line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pixelTick | input | 1 | One-cycle strobe per pixel period |
| sensorSel | input | 3 | Line-length select code |
| intSel | input | 3 | Integration select (low two bits used) |
| redCode | input | 4 | Red exposure-gate code |
| greenCode | input | 4 | Green exposure-gate code |
| tg1 | output | 1 | First transfer-gate pulse |
| tg2 | output | 1 | Second transfer-gate pulse |
| expRed | output | 1 | Red exposure-control gate |
| expGreen | output | 1 | Green exposure-control gate |
| lineSync | output | 1 | Line sync for frame grabber |
| frameSync | output | 1 | Frame sync, transfer lines only |

## Verification
The hardest cases to reach from the ports are a setting that changes in the middle of a line or an integration group, and an exposure window clipped by the line end. The stimulus covers the first case by lowering the integration code from 3 to 0 partway through a group, and by switching the sensor code a few dozen ticks into a short line. It covers the second by running 2472-pixel lines with codes whose windows run past the line end. The table's long line lengths are run end to end with dense ticks. Short lines run with sparse ticks, so that cycles without a tick fall at every pixel position.

// File: rtl/ccdSeqPkg.sv
package ccdSeqPkg;

  typedef struct packed {
    logic running;
    logic xferLine;
    logic tg1Win;
    logic tg2Win;
    logic syncWin;
  } seqStrobe_t;

  function automatic logic [15:0] lineLenOf(input logic [2:0] sel);
    logic [15:0] len;
    case (sel)
      3'd0: len = 16'd2872;
      3'd1: len = 16'd6372;
      3'd2: len = 16'd8572;
      3'd3: len = 16'd10372;
      3'd4: len = 16'd2472;
      3'd5: len = 16'd14972;
      3'd6: len = 16'd172;
      default: len = 16'd14972;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/ccdLineCtl.sv
module ccdLineCtl import ccdSeqPkg::*; #(
  parameter int PIX_W    = 14,
  parameter int INT_W    = 2,
  parameter int TG1_PIX  = 21,
  parameter int TG2_PIX  = 26,
  parameter int SYNC_PIX = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pixelTick,
  input  logic [2:0]       sensorSel,
  input  logic [INT_W:0]   intSel,
  output seqStrobe_t       strobes,
  output logic [PIX_W-1:0] pixCnt
);

  localparam logic [INT_W:0] INT_MASK = {1'b0, {INT_W{1'b1}}};

  logic             running;
  logic [PIX_W-1:0] lineLen;
  logic [INT_W-1:0] grpIdx;
  logic [PIX_W-1:0] newLen;
  logic [INT_W-1:0] newInt;
  logic             lastPix;
  logic             lineStart;

  assign newLen    = PIX_W'(lineLenOf(sensorSel));
  assign newInt    = INT_W'(intSel & INT_MASK);
  assign lastPix   = (pixCnt == lineLen - PIX_W'(1));
  assign lineStart = pixelTick && (!running || lastPix);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pixCnt  <= '0;
      lineLen <= newLen;
      grpIdx  <= '0;
    end else if (lineStart) begin
      running <= 1'b1;
      pixCnt  <= '0;
      lineLen <= newLen;
      grpIdx  <= (!running || grpIdx >= newInt) ? '0 : grpIdx + INT_W'(1);
    end else if (pixelTick) begin
      pixCnt <= pixCnt + PIX_W'(1);
    end
  end

  always_comb begin
    strobes.running  = running;
    strobes.xferLine = running && (grpIdx == '0);
    strobes.tg1Win   = strobes.xferLine && (pixCnt < PIX_W'(TG1_PIX));
    strobes.tg2Win   = strobes.xferLine && (pixCnt < PIX_W'(TG2_PIX));
    strobes.syncWin  = running && (pixCnt < PIX_W'(SYNC_PIX));
  end

  // R1: the position wraps to zero after the last pixel of a line
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (running && pixelTick && lastPix) |=> (pixCnt == '0));

  // R1: a cycle without a tick keeps the position
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !pixelTick) |=> $stable(pixCnt));

  // R1: the position stays inside the current line
  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pixCnt < lineLen));

  // R10: the line length only changes at a line start
  a_r10_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(pixelTick && lastPix)) |=> $stable(lineLen));

endmodule

// File: rtl/ccdExposureGate.sv
module ccdExposureGate import ccdSeqPkg::*; #(
  parameter int PIX_W    = 14,
  parameter int CODE_W   = 4,
  parameter int STEP_PIX = 500,
  parameter int START    = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobes,
  input  logic [PIX_W-1:0]  pixCnt,
  input  logic [CODE_W-1:0] code,
  output logic              gate
);

  localparam logic [CODE_W-1:0] CODE_OFF = '0;
  localparam logic [CODE_W-1:0] CODE_ON  = '1;

  int stopPix;
  int pixInt;

  always_comb begin
    pixInt  = int'(pixCnt);
    stopPix = START + int'(code) * STEP_PIX;
    if (!strobes.running || code == CODE_OFF) begin
      gate = 1'b0;
    end else if (code == CODE_ON) begin
      gate = !strobes.tg2Win;
    end else begin
      gate = (pixInt >= START) && (pixInt < stopPix);
    end
  end

  // R7: code zero never opens the gate
  a_r7_off: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_OFF) |-> !gate);

  // R8: the always-on code is low while the transfer gate is active
  a_r8_low_in_tg: assert property (@(posedge clk) disable iff (!rst_n)
    (code == CODE_ON && strobes.tg2Win) |-> !gate);

  // R6: no code opens the gate while the first transfer gate is active
  a_r6_not_during_tg1: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.tg1Win |-> !gate);

endmodule

// File: rtl/ccdLineSequencer.sv
module ccdLineSequencer import ccdSeqPkg::*; #(
  parameter int PIX_W    = 14,
  parameter int INT_W    = 2,
  parameter int CODE_W   = 4,
  parameter int TG1_PIX  = 21,
  parameter int TG2_PIX  = 26,
  parameter int SYNC_PIX = 10,
  parameter int STEP_PIX = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pixelTick,
  input  logic [2:0]        sensorSel,
  input  logic [INT_W:0]    intSel,
  input  logic [CODE_W-1:0] redCode,
  input  logic [CODE_W-1:0] greenCode,
  output logic              tg1,
  output logic              tg2,
  output logic              expRed,
  output logic              expGreen,
  output logic              lineSync,
  output logic              frameSync
);

  localparam int N_COLOR = 2;

  seqStrobe_t        strobes;
  logic [PIX_W-1:0]  pixCnt;
  logic [CODE_W-1:0] codes [N_COLOR];
  logic              gates [N_COLOR];

  assign codes[0] = redCode;
  assign codes[1] = greenCode;

  ccdLineCtl #(
    .PIX_W(PIX_W), .INT_W(INT_W), .TG1_PIX(TG1_PIX),
    .TG2_PIX(TG2_PIX), .SYNC_PIX(SYNC_PIX)
  ) uCtl (
    .clk(clk), .rst_n(rst_n), .pixelTick(pixelTick),
    .sensorSel(sensorSel), .intSel(intSel),
    .strobes(strobes), .pixCnt(pixCnt)
  );

  for (genvar c = 0; c < N_COLOR; c++) begin : gColor
    ccdExposureGate #(
      .PIX_W(PIX_W), .CODE_W(CODE_W), .STEP_PIX(STEP_PIX), .START(TG2_PIX)
    ) uGate (
      .clk(clk), .rst_n(rst_n), .strobes(strobes),
      .pixCnt(pixCnt), .code(codes[c]), .gate(gates[c])
    );
  end

  assign tg1       = strobes.tg1Win;
  assign tg2       = strobes.tg2Win;
  assign lineSync  = strobes.syncWin;
  assign frameSync = strobes.syncWin && strobes.xferLine;
  assign expRed    = gates[0];
  assign expGreen  = gates[1];

  // R2: the first transfer pulse lies inside the second
  a_r2_tg_nest: assert property (@(posedge clk) disable iff (!rst_n)
    tg1 |-> tg2);

  // R5: frame sync only appears inside a line sync
  a_r5_frame_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    frameSync |-> lineSync);

  // R11: the first tick after reset opens a transfer line
  a_r11_first_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.running && pixelTick) |=> (tg1 && frameSync));

endmodule

// File: tb/sim_ccdLineSequencer.sv
module sim_ccdLineSequencer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pixelTick = 1'b0;
  logic [2:0] sensorSel = 3'd6;
  logic [2:0] intSel = 3'd0;
  logic [3:0] redCode = 4'd0;
  logic [3:0] greenCode = 4'd0;
  logic tg1, tg2, expRed, expGreen, lineSync, frameSync;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int tickMode = 0;
  string phase = "R11 idle after reset";

  // reference model state
  int mRun = 0, mPix = 0, mSince = 0, mLen = 172, mLineCount = 0;

  always #10 clk = ~clk;

  ccdLineSequencer u0 (
    .clk(clk), .rst_n(rst_n), .pixelTick(pixelTick),
    .sensorSel(sensorSel), .intSel(intSel),
    .redCode(redCode), .greenCode(greenCode),
    .tg1(tg1), .tg2(tg2), .expRed(expRed), .expGreen(expGreen),
    .lineSync(lineSync), .frameSync(frameSync)
  );

  function automatic int lenOf(input int sel);
    case (sel)
      0: return 2872;
      1: return 6372;
      2: return 8572;
      3: return 10372;
      4: return 2472;
      5: return 14972;
      6: return 172;
      default: return 14972;
    endcase
  endfunction

  function automatic bit gateOf(input int code);
    bit xfer;
    xfer = (mRun != 0) && (mSince == 0);
    if (mRun == 0 || code == 0) return 1'b0;
    if (code == 15) return !(xfer && mPix < 26);
    return (mPix >= 26) && (mPix < 26 + 500 * code);
  endfunction

  function automatic string gateTag(input int code);
    if (code == 0) return "R7";
    if (code == 15) return "R8";
    return "R6";
  endfunction

  // model update on the active edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mRun = 0; mPix = 0; mSince = 0;
    end else if (pixelTick) begin
      if (mRun == 0 || mPix == mLen - 1) begin
        if (mRun == 0) mSince = 0;
        else begin
          mSince = mSince + 1;
          if (mSince >= (intSel % 4) + 1) mSince = 0;
        end
        mRun = 1; mPix = 0; mLen = lenOf(int'(sensorSel));
        mLineCount++;
      end else begin
        mPix++;
      end
    end
  end

  task automatic cmp(input string tag, input string name, input bit got, input bit exp);
    if (got !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s got %0b expected %0b (pix %0d, cycle %0d)",
               tag, phase, name, got, exp, mPix, cyc);
    end
  endtask

  // compare away from the edges
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      bit xfer;
      xfer = (mRun != 0) && (mSince == 0);
      checks++;
      cmp("R2", "tg1", tg1, xfer && mPix < 21);
      cmp("R2", "tg2", tg2, xfer && mPix < 26);
      cmp("R4", "lineSync", lineSync, (mRun != 0) && mPix < 10);
      cmp("R5", "frameSync", frameSync, xfer && mPix < 10);
      cmp(gateTag(int'(redCode)), "expRed", expRed, gateOf(int'(redCode)));
      cmp(gateTag(int'(greenCode)), "expGreen", expGreen, gateOf(int'(greenCode)));
    end
  end

  // tick generator
  always @(negedge clk) begin
    if (tickMode == 1) pixelTick <= 1'b1;
    else if (tickMode == 2) pixelTick <= (cyc % 3 == 0);
    else pixelTick <= 1'b0;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog [%s] got running expected finished", phase);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitLines(input int n);
    int target;
    target = mLineCount + n;
    while (mLineCount < target) @(negedge clk);
  endtask

  initial begin
    waitCycles(5);
    rst_n = 1'b1;
    // R11: no tick yet, every output low
    waitCycles(6);

    phase = "R1 short line dense ticks";
    redCode = 4'd15; greenCode = 4'd0;
    tickMode = 1;
    waitLines(3);

    phase = "R3 integration of three lines, sparse ticks";
    intSel = 3'd2; tickMode = 2;
    waitLines(7);

    phase = "R3 setting bit 2 ignored";
    intSel = 3'd6;
    waitLines(6);

    phase = "R6 windows clipped by short line";
    redCode = 4'd1; greenCode = 4'd14; tickMode = 1;
    waitLines(2);

    phase = "R10 settings changed mid-line";
    waitCycles(50);
    sensorSel = 3'd4; intSel = 3'd1;
    redCode = 4'd3; greenCode = 4'd5;
    waitLines(4);

    phase = "R9 independent colour codes";
    redCode = 4'd9; greenCode = 4'd2;
    waitLines(1);
    waitCycles(700);
    redCode = 4'd0;
    waitLines(1);

    phase = "R3 integration lowered mid-group";
    sensorSel = 3'd6; intSel = 3'd3; redCode = 4'd15; greenCode = 4'd15;
    waitLines(3);
    intSel = 3'd0;
    waitLines(3);

    phase = "R1 length table";
    redCode = 4'd14; greenCode = 4'd15;
    for (int s = 0; s < 8; s++) begin
      if (s == 4 || s == 6) continue;
      sensorSel = 3'(s);
      waitLines(2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule